// File: doc/BRIEF.md
# Coherence Directory Controller

This block is the home agent for a small set of private caches. It keeps one directory entry per memory block. Each entry holds a coherence state (uncached, shared, or owned, where owned covers both exclusive and modified) and a holder vector with one bit per core. Cores send read misses, write misses and write-back notices over one request channel. The controller looks up the entry and decides whether the request can be granted at once from memory. If it cannot, it sends a single point-to-point coherence message to the caches marked in the holder vector. That message is a downgrade for a read of an owned block, or an invalidate for a write.

When coherence action is needed, the controller records the set of targeted caches and a count of the acknowledgements still due. It closes the request channel until every targeted cache has answered, then sends the grant and updates the entry. Acknowledgements from caches that were not targeted, and repeated acknowledgements, are ignored. Memory data movement and the interconnect lie outside the block. The grant only says whether the owner forwarded the data and whether the requester now holds the block with modify rights.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every entry is uncached with an empty holder vector, `req_ready` is 1, and `gnt_valid` and `snp_valid` are 0.
- R2: A read (`req_op`=0) to an uncached block, or by the sole owner of an owned block, is granted on the cycle after acceptance with `gnt_excl`=1, `gnt_fwd`=0 and no coherence message. The requester becomes sole owner.
- R3: A read to a shared block is granted on the cycle after acceptance with `gnt_excl`=0, `gnt_fwd`=0 and no coherence message. The requester's bit is added and the state stays shared.
- R4: A read to a block owned by another core sends one message on the cycle after acceptance with `snp_inv`=0 (downgrade) and `snp_mask` equal to the owner alone. After that owner acknowledges, the grant carries `gnt_excl`=0 and `gnt_fwd`=1, and the entry becomes shared by both cores.
- R5: A write (`req_op`=1) to a block held by other cores sends one message with `snp_inv`=1 and `snp_mask` equal to the holders minus the requester. The grant has `gnt_excl`=1, and `gnt_fwd`=1 exactly when the block was owned.
- R6: A write to a block that no other core holds is granted on the cycle after acceptance with `gnt_excl`=1, `gnt_fwd`=0 and no coherence message.
- R7: After a write grant, the requester is the only holder, so a later read by another core downgrades that writer alone.
- R8: While acknowledgements are outstanding, `req_ready` is 0 and no new request is accepted.
- R9: Acknowledgements from caches outside the targeted set, and repeated acknowledgements from one cache, do not count toward completion.
- R10: A write-back notice (`req_op`=2) clears the sender's bit without a grant or message. An entry left with no holders becomes uncached.
- R11: The grant appears on the cycle after the clock edge at which the last outstanding acknowledgement is taken, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_core | input | $clog2(NCORE) | Requesting core index |
| req_blk | input | $clog2(NBLK) | Block index |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| snp_valid | output | 1 | Coherence message valid (one cycle) |
| snp_inv | output | 1 | 1 invalidate, 0 downgrade |
| snp_blk | output | $clog2(NBLK) | Block targeted by the message |
| snp_mask | output | NCORE | Caches the message is sent to |
| ack_valid | input | NCORE | Per-cache acknowledgement strobes |
| gnt_valid | output | 1 | Grant valid (one cycle) |
| gnt_core | output | $clog2(NCORE) | Core receiving the grant |
| gnt_blk | output | $clog2(NBLK) | Block granted |
| gnt_excl | output | 1 | Requester now holds the block with modify rights |
| gnt_fwd | output | 1 | Data was supplied by the previous owner |

## Verification
The sweep starts from every subset of holders on four cores, applies a read and a write from each core, and follows every write with a read by a different core. A design that sent messages by broadcast, or that left old sharers in the vector after a write, would show an extra bit in `snp_mask`. During every wait the bench first acknowledges from the requester, which was never targeted, and then repeats the first real acknowledgement. A controller that counted raw strobes would grant early, and one that ignored the targeted set would grant while invalidations were still due. Write-back cleanup followed by a fresh read exposes entries that fail to return to uncached, because the read then comes back shared instead of exclusive.

// File: rtl/coh_pkg.sv
// Shared types for the coherence directory controller.
// Assumes: encodings below are visible at the request port as plain bits.
package coh_pkg;

    typedef enum logic [1:0] {
        DIR_UNC = 2'd0,
        DIR_SHR = 2'd1,
        DIR_OWN = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        OP_RD = 2'd0,
        OP_WR = 2'd1,
        OP_WB = 2'd2
    } req_op_e;

endpackage

// File: rtl/coh_dir_store.sv
// Directory storage: one state and holder vector per block.
// Assumes: one combinational read port and one synchronous write port;
// the write is applied on the clock edge and seen by reads afterwards.
module coh_dir_store
    import coh_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NBLK  = 8,
    localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    rd_blk,
    output dir_state_e       rd_state,
    output logic [NCORE-1:0] rd_vec,
    input  logic             wr_en,
    input  logic [BW-1:0]    wr_blk,
    input  dir_state_e       wr_state,
    input  logic [NCORE-1:0] wr_vec
);

    dir_state_e       st_q  [NBLK];
    logic [NCORE-1:0] vec_q [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_entry
        // Holds one directory entry; cleared to uncached by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[b]  <= DIR_UNC;
                vec_q[b] <= '0;
            end else if (wr_en && (wr_blk == BW'(b))) begin
                st_q[b]  <= wr_state;
                vec_q[b] <= wr_vec;
            end
        end
    end

    // Read port for the block under decision.
    always_comb begin
        rd_state = st_q[rd_blk];
        rd_vec   = vec_q[rd_blk];
    end

endmodule

// File: rtl/coh_ack_tracker.sv
// Tracks which targeted caches still owe an acknowledgement and how many.
// Assumes: load and acknowledgements never overlap (acks are only taken
// after the load edge). Strobes outside the pending set are dropped.
module coh_ack_tracker #(
    parameter int NCORE = 4,
    localparam int CW   = $clog2(NCORE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NCORE-1:0] load_mask,
    input  logic [NCORE-1:0] ack_valid,
    output logic [NCORE-1:0] pend_mask,
    output logic [CW-1:0]    pend_cnt,
    output logic             done
);

    logic [NCORE-1:0] taken;

    function automatic logic [CW-1:0] popc(input logic [NCORE-1:0] v);
        logic [CW-1:0] n;
        n = '0;
        for (int i = 0; i < NCORE; i++) n = n + CW'(v[i]);
        return n;
    endfunction

    // Acknowledgements that actually retire a pending target.
    always_comb begin
        taken = ack_valid & pend_mask;
        done  = (pend_mask != '0) && ((pend_mask & ~ack_valid) == '0);
    end

    // Pending set and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_mask <= '0;
            pend_cnt  <= '0;
        end else if (load) begin
            pend_mask <= load_mask;
            pend_cnt  <= popc(load_mask);
        end else begin
            pend_mask <= pend_mask & ~taken;
            pend_cnt  <= pend_cnt - popc(taken);
        end
    end

endmodule

// File: rtl/coh_dir_ctrl.sv
// Coherence directory controller top. Decides per request whether a
// grant can be given from memory, or whether the recorded holders must be
// downgraded/invalidated first; waits for all acks, then grants.
// Assumes: NCORE >= 2; one transaction in flight at a time, so any
// request arriving during a wait is held off by req_ready.
module coh_dir_ctrl
    import coh_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NBLK  = 8,
    localparam int CIW  = $clog2(NCORE),
    localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int CW   = $clog2(NCORE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CIW-1:0]   req_core,
    input  logic [BW-1:0]    req_blk,
    input  logic [1:0]       req_op,
    output logic             snp_valid,
    output logic             snp_inv,
    output logic [BW-1:0]    snp_blk,
    output logic [NCORE-1:0] snp_mask,
    input  logic [NCORE-1:0] ack_valid,
    output logic             gnt_valid,
    output logic [CIW-1:0]   gnt_core,
    output logic [BW-1:0]    gnt_blk,
    output logic             gnt_excl,
    output logic             gnt_fwd
);

    logic             in_wait_q;
    logic [CIW-1:0]   txn_core_q;
    logic [BW-1:0]    txn_blk_q;
    logic             txn_wr_q;
    logic             txn_fwd_q;

    logic [BW-1:0]    look_blk;
    dir_state_e       cur_st;
    logic [NCORE-1:0] cur_vec;
    logic             wr_en;
    dir_state_e       nxt_st;
    logic [NCORE-1:0] nxt_vec;

    logic             accept;
    logic [NCORE-1:0] req_bit;
    logic [NCORE-1:0] txn_bit;
    logic [NCORE-1:0] others;
    logic             need_snp;
    logic             dec_inv;
    logic             dec_excl;
    logic             dec_gnt;
    logic             dec_fwd;
    req_op_e          op;

    logic [NCORE-1:0] pend_mask;
    logic [CW-1:0]    pend_cnt;
    logic             trk_done;

    coh_dir_store #(.NCORE(NCORE), .NBLK(NBLK)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_blk   (look_blk),
        .rd_state (cur_st),
        .rd_vec   (cur_vec),
        .wr_en    (wr_en),
        .wr_blk   (look_blk),
        .wr_state (nxt_st),
        .wr_vec   (nxt_vec)
    );

    coh_ack_tracker #(.NCORE(NCORE)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && need_snp),
        .load_mask (others),
        .ack_valid (ack_valid),
        .pend_mask (pend_mask),
        .pend_cnt  (pend_cnt),
        .done      (trk_done)
    );

    // Handshake and decode of the incoming request.
    always_comb begin
        req_ready = !in_wait_q;
        accept    = req_valid && !in_wait_q;
        look_blk  = in_wait_q ? txn_blk_q : req_blk;
        op        = req_op_e'(req_op);
        req_bit   = NCORE'(1) << req_core;
        txn_bit   = NCORE'(1) << txn_core_q;
        others    = cur_vec & ~req_bit;
    end

    // Decide the action and the next entry value.
    always_comb begin
        need_snp = 1'b0;
        dec_inv  = 1'b0;
        dec_excl = 1'b0;
        dec_gnt  = 1'b0;
        dec_fwd  = 1'b0;
        nxt_st   = cur_st;
        nxt_vec  = cur_vec;
        if (in_wait_q) begin
            nxt_st  = txn_wr_q ? DIR_OWN : DIR_SHR;
            nxt_vec = txn_wr_q ? txn_bit : (cur_vec | txn_bit);
        end else begin
            unique case (op)
                OP_RD: begin
                    if (cur_st == DIR_OWN && others != '0) begin
                        need_snp = 1'b1;
                        dec_fwd  = 1'b1;
                    end else if (cur_st == DIR_SHR) begin
                        dec_gnt = 1'b1;
                        nxt_vec = cur_vec | req_bit;
                    end else begin
                        dec_gnt  = 1'b1;
                        dec_excl = 1'b1;
                        nxt_st   = DIR_OWN;
                        nxt_vec  = req_bit;
                    end
                end
                OP_WR: begin
                    dec_excl = 1'b1;
                    if (others != '0) begin
                        need_snp = 1'b1;
                        dec_inv  = 1'b1;
                        dec_fwd  = (cur_st == DIR_OWN);
                    end else begin
                        dec_gnt = 1'b1;
                        nxt_st  = DIR_OWN;
                        nxt_vec = req_bit;
                    end
                end
                default: begin
                    nxt_vec = cur_vec & ~req_bit;
                    nxt_st  = (nxt_vec == '0) ? DIR_UNC : cur_st;
                end
            endcase
        end
        wr_en = (accept && !need_snp) || (in_wait_q && trk_done);
    end

    // Transaction state and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_wait_q  <= 1'b0;
            txn_core_q <= '0;
            txn_blk_q  <= '0;
            txn_wr_q   <= 1'b0;
            txn_fwd_q  <= 1'b0;
            snp_valid  <= 1'b0;
            snp_inv    <= 1'b0;
            snp_blk    <= '0;
            snp_mask   <= '0;
            gnt_valid  <= 1'b0;
            gnt_core   <= '0;
            gnt_blk    <= '0;
            gnt_excl   <= 1'b0;
            gnt_fwd    <= 1'b0;
        end else begin
            snp_valid <= 1'b0;
            gnt_valid <= 1'b0;
            if (accept && need_snp) begin
                in_wait_q  <= 1'b1;
                txn_core_q <= req_core;
                txn_blk_q  <= req_blk;
                txn_wr_q   <= dec_excl;
                txn_fwd_q  <= dec_fwd;
                snp_valid  <= 1'b1;
                snp_inv    <= dec_inv;
                snp_blk    <= req_blk;
                snp_mask   <= others;
            end else if (accept && dec_gnt) begin
                gnt_valid <= 1'b1;
                gnt_core  <= req_core;
                gnt_blk   <= req_blk;
                gnt_excl  <= dec_excl;
                gnt_fwd   <= 1'b0;
            end else if (in_wait_q && trk_done) begin
                in_wait_q <= 1'b0;
                gnt_valid <= 1'b1;
                gnt_core  <= txn_core_q;
                gnt_blk   <= txn_blk_q;
                gnt_excl  <= txn_wr_q;
                gnt_fwd   <= txn_fwd_q;
            end
        end
    end

endmodule

// File: rtl/coh_dir_ctrl_chk.sv
// Protocol checker for coh_dir_ctrl, attached by bind.
// Assumes: observes the top ports plus the tracker and transaction state.
module coh_dir_ctrl_chk #(
    parameter int NCORE = 4,
    parameter int CIW   = 2,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             snp_valid,
    input logic [NCORE-1:0] snp_mask,
    input logic             gnt_valid,
    input logic [NCORE-1:0] ack_valid,
    input logic             in_wait,
    input logic [NCORE-1:0] pend_mask,
    input logic [CW-1:0]    pend_cnt,
    input logic [CIW-1:0]   txn_core
);

    // R8: no acceptance while acknowledgements are due
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt != '0) |-> !req_ready);

    // R5: the requester is never among the message targets
    p_no_self_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !snp_mask[txn_core]);

    // R4: a message always has at least one target
    p_snoop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (snp_mask != '0));

    // R9: pending count tracks the pending set
    p_count_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt == CW'($countones(pend_mask)));

    // R9: while waiting, the count never rises
    p_count_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && $past(in_wait)) |-> (pend_cnt <= $past(pend_cnt)));

    // R11: last ack taken leads to a grant on the next cycle
    p_grant_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && pend_mask != '0 && (pend_mask & ~ack_valid) == '0) |=> gnt_valid);

    // R2: grant and message never share a cycle
    p_excl_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_valid && snp_valid));

endmodule

bind coh_dir_ctrl coh_dir_ctrl_chk #(.NCORE(NCORE), .CIW(CIW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .snp_valid (snp_valid),
    .snp_mask  (snp_mask),
    .gnt_valid (gnt_valid),
    .ack_valid (ack_valid),
    .in_wait   (in_wait_q),
    .pend_mask (pend_mask),
    .pend_cnt  (pend_cnt),
    .txn_core  (txn_core_q)
);

// File: tb/coh_dir_ctrl_test.sv
`timescale 1ns/1ps
module coh_dir_ctrl_test;

    localparam int NC = 4;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_core = '0;
    logic [2:0]    req_blk = '0;
    logic [1:0]    req_op = '0;
    logic          snp_valid;
    logic          snp_inv;
    logic [2:0]    snp_blk;
    logic [NC-1:0] snp_mask;
    logic [NC-1:0] ack_valid = '0;
    logic          gnt_valid;
    logic [1:0]    gnt_core;
    logic [2:0]    gnt_blk;
    logic          gnt_excl;
    logic          gnt_fwd;

    int tests = 0;
    int fails = 0;

    int            m_st  [NB];
    logic [NC-1:0] m_vec [NB];

    always #4 clk = ~clk;

    coh_dir_ctrl #(.NCORE(NC), .NBLK(NB)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_core(req_core), .req_blk(req_blk), .req_op(req_op),
        .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_blk(snp_blk),
        .snp_mask(snp_mask), .ack_valid(ack_valid),
        .gnt_valid(gnt_valid), .gnt_core(gnt_core), .gnt_blk(gnt_blk),
        .gnt_excl(gnt_excl), .gnt_fwd(gnt_fwd)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        ack_valid = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < NB; b++) begin
            m_st[b]  = 0;
            m_vec[b] = '0;
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(gnt_valid == 1'b0, "R1", "no grant after reset", int'(gnt_valid), 0);
        chk(snp_valid == 1'b0, "R1", "no message after reset", int'(snp_valid), 0);
    endtask

    // One acknowledgement cycle; checks that the grant shows only when last.
    task automatic ack_step(input logic [NC-1:0] bits, input bit last, input string tag);
        ack_valid = bits;
        @(negedge clk);
        ack_valid = '0;
        chk(gnt_valid == last, tag, "grant timing", int'(gnt_valid), int'(last));
        if (!last)
            chk(req_ready == 1'b0, "R8", "ready held low while waiting", int'(req_ready), 0);
    endtask

    // Issue one request, answer any coherence message, check against the model.
    task automatic do_op(input int c, input int b, input int op, input string tag_in);
        logic [NC-1:0] rb, oth, emask, rem, nvec;
        bit   esnp, einv, eexcl, efwd, egnt;
        int   nst, f;
        string tag;
        rb = NC'(1) << c;
        oth = m_vec[b] & ~rb;
        esnp = 0; einv = 0; eexcl = 0; efwd = 0; egnt = 0; emask = '0;
        nst = m_st[b]; nvec = m_vec[b];
        if (op == 0) begin
            if (m_st[b] == 2 && oth != '0) begin
                esnp = 1; emask = oth; efwd = 1; egnt = 1;
                nst = 1; nvec = m_vec[b] | rb; tag = "R4";
            end else if (m_st[b] == 1) begin
                egnt = 1; nvec = m_vec[b] | rb; tag = "R3";
            end else begin
                egnt = 1; eexcl = 1; nst = 2; nvec = rb; tag = "R2";
            end
        end else if (op == 1) begin
            egnt = 1; eexcl = 1; nst = 2; nvec = rb;
            if (oth != '0) begin
                esnp = 1; einv = 1; emask = oth; efwd = (m_st[b] == 2); tag = "R5";
            end else tag = "R6";
        end else begin
            nvec = m_vec[b] & ~rb;
            nst = (nvec == '0) ? 0 : m_st[b];
            tag = "R10";
        end
        if (tag_in != "") tag = tag_in;

        @(negedge clk);
        req_valid = 1'b1; req_core = 2'(c); req_blk = 3'(b); req_op = 2'(op);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;

        if (esnp) begin
            chk(snp_valid == 1'b1, tag, "message sent", int'(snp_valid), 1);
            chk(snp_mask == emask, tag, "message targets", int'(snp_mask), int'(emask));
            chk(snp_inv == einv, tag, "message kind", int'(snp_inv), int'(einv));
            chk(snp_blk == 3'(b), tag, "message block", int'(snp_blk), b);
            chk(gnt_valid == 1'b0, "R11", "no early grant", int'(gnt_valid), 0);
            f = 0;
            for (int i = NC - 1; i >= 0; i--) if (emask[i]) f = i;
            rem = emask & ~(NC'(1) << f);
            ack_step(rb, 1'b0, "R9");
            ack_step(NC'(1) << f, rem == '0, "R11");
            if (rem != '0) begin
                ack_step(NC'(1) << f, 1'b0, "R9");
                for (int i = 0; i < NC; i++) begin
                    if (rem[i]) begin
                        rem[i] = 1'b0;
                        ack_step(NC'(1) << i, rem == '0, "R11");
                    end
                end
            end
        end else begin
            chk(snp_valid == 1'b0, tag, "no message", int'(snp_valid), 0);
            chk(gnt_valid == egnt, tag, "grant present", int'(gnt_valid), int'(egnt));
        end
        if (egnt && gnt_valid) begin
            chk(gnt_core == 2'(c), tag, "grant core", int'(gnt_core), c);
            chk(gnt_blk == 3'(b), tag, "grant block", int'(gnt_blk), b);
            chk(gnt_excl == eexcl, tag, "grant exclusive", int'(gnt_excl), int'(eexcl));
            chk(gnt_fwd == efwd, tag, "grant forwarded", int'(gnt_fwd), int'(efwd));
        end
        m_st[b] = nst;
        m_vec[b] = nvec;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] lf;
        do_reset();

        // Sweep over every starting holder set, requester and miss kind.
        for (int s = 0; s < 16; s++) begin
            for (int r = 0; r < NC; r++) begin
                for (int op = 0; op < 2; op++) begin
                    int b;
                    b = (s + r) % NB;
                    for (int c = 0; c < NC; c++)
                        if (s[c]) do_op(c, b, 0, "");
                    do_op(r, b, op, "");
                    if (op == 1) do_op((r + 1) % NC, b, 0, "R7");
                    for (int c = 0; c < NC; c++)
                        if (m_vec[b][c]) do_op(c, b, 2, "");
                    do_op(r, b, 0, "R10");
                    do_op(r, b, 2, "");
                end
            end
        end

        // Pseudo-random mix across all blocks.
        lf = 16'hACE1;
        for (int n = 0; n < 500; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_op(int'(lf[3:2]), int'(lf[6:4]), int'(lf[1:0]) % 3, "");
        end

        // Reset with live owners must return every entry to uncached.
        do_reset();
        for (int b = 0; b < NB; b++) do_op(b % NC, b, 0, "R1");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule